// File: doc/BRIEF.md
# Narrow-to-Wide Read Request Coalescer

This block sits between a source of scattered 64-bit word reads and a memory port that serves whole 512-bit lines. Each incoming read carries a word address and a tag. The block keeps a small window of open line entries. Every read that falls in a line which already has an open, unissued entry joins that entry, so one wide read serves all of them. Entries go to the memory port in the order they were opened. When a line comes back, the block hands out the requested words one by one, each with the tag it arrived with.

Each entry acts as its own metadata record. Its index is the line ID sent with the wide read, and it keeps the list of (tag, word select) pairs that the line must serve. Because of this, lines may return in any order. A limit on outstanding wide reads and a hold time before an entry issues trade merging chances against latency.

Top module: `rcl_coalescer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and mem_req_valid is 0.
- R2: A request whose line (in_waddr[WADDR_W-1:3]) equals that of an open, unissued entry with a free slot joins that entry and causes no extra line read; the line read carries mem_req_line equal to that line.
- R3: An entry holds at most SLOTS requests; a further request to the same line opens a new entry, which gets its own line read.
- R4: Line reads leave in the order entries were opened. The oldest unissued entry is offered once it has aged HOLD cycles since opening, or once all ENTRIES entries are occupied, or once its slots are full.
- R5: in_ready is 0 exactly while all ENTRIES entries are occupied, and it returns to 1 once a line has been fully handed out.
- R6: No more than MAX_INFLIGHT line reads are outstanding (accepted on the request channel, not yet accepted on the response channel).
- R7: Each output word is bits [64*s +: 64] of the returned line, where s = in_waddr[2:0] of its request, and out_tag equals that request's tag.
- R8: Line responses may arrive in any order, identified by mem_rsp_id equal to the mem_req_id given at issue; every accepted request produces exactly one output.
- R9: The words of one line are output one per handshake, in the order their requests were accepted; out_valid, out_tag and out_data hold steady while out_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Narrow read request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_waddr | input | WADDR_W | 64-bit word address; low 3 bits pick the word in its line |
| in_tag | input | TAG_W | Request tag returned with the data |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the line read |
| mem_req_line | output | WADDR_W-3 | Line address to read |
| mem_req_id | output | log2(ENTRIES) | Line ID that the response must carry |
| mem_rsp_valid | input | 1 | Line data valid |
| mem_rsp_ready | output | 1 | Block accepts the line data |
| mem_rsp_id | input | log2(ENTRIES) | Line ID of the returned data |
| mem_rsp_data | input | 512 | Returned line, word k in bits [64k +: 64] |
| out_valid | output | 1 | Returned word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_tag | output | TAG_W | Tag of the request this word serves |
| out_data | output | 64 | Requested 64-bit word |

## Verification
The hardest case to reach from the ports is a full window where every entry waits behind the cap on outstanding reads while the responses come back in reverse. The bench gets there by holding the memory's request ready low while it opens one entry per line until in_ready drops. It then accepts reads with returns disabled, so the cap is visible, and then releases the responses last-in-first-out. A word-major sweep over four lines interleaves requests across entries, toggles out_ready and fills slots to overflow. Every output is checked against an arithmetic line image and against per-line arrival order.

// File: rtl/rcl_pkg.sv
`timescale 1ns/1ps
package rcl_pkg;
    localparam int WORD_W     = 64;
    localparam int LINE_WORDS = 8;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int SEL_W      = 3;

    typedef logic [SEL_W-1:0] wsel_t;

    typedef enum logic {
        FO_IDLE = 1'b0,
        FO_SEND = 1'b1
    } fo_state_e;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input wsel_t sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/rcl_match.sv
`timescale 1ns/1ps
module rcl_match #(
    parameter int ENTRIES = 4,
    parameter int SLOTS   = 4,
    parameter int LADDR_W = 10,
    parameter int CNT_W   = 3,
    parameter int ID_W    = 2
) (
    input  logic [ENTRIES-1:0] e_valid,
    input  logic [ENTRIES-1:0] e_issued,
    input  logic [LADDR_W-1:0] e_line [ENTRIES],
    input  logic [CNT_W-1:0]   e_cnt  [ENTRIES],
    input  logic [LADDR_W-1:0] req_line,
    output logic               hit,
    output logic [ID_W-1:0]    hit_id,
    output logic [ID_W-1:0]    free_id
);
    always_comb begin
        hit    = 1'b0;
        hit_id = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && e_valid[i] && !e_issued[i] && e_line[i] == req_line &&
                e_cnt[i] < CNT_W'(SLOTS)) begin
                hit    = 1'b1;
                hit_id = ID_W'(i);
            end
        end
    end

    always_comb begin
        free_id = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!e_valid[i]) free_id = ID_W'(i);
        end
    end
endmodule

// File: rtl/rcl_order_fifo.sv
`timescale 1ns/1ps
module rcl_order_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout  = mem[rd_q];
    assign empty = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    // R4
    fifo_room_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH) || pop));
    // R4
    fifo_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/rcl_fanout.sv
`timescale 1ns/1ps
module rcl_fanout
    import rcl_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int SLOT_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [LINE_W-1:0] rsp_data,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  wsel_t             cur_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [ID_W-1:0]   cur_id,
    output logic [SLOT_W-1:0] cur_idx,
    output logic              done
);
    fo_state_e         state_q;
    logic [LINE_W-1:0] line_q;

    assign rsp_ready = (state_q == FO_IDLE);
    assign out_valid = (state_q == FO_SEND);
    assign out_data  = pick_word(line_q, cur_sel);
    assign done      = out_valid && out_ready &&
                       (CNT_W'(cur_idx) + CNT_W'(1) == cur_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FO_IDLE;
            cur_id  <= '0;
            cur_idx <= '0;
        end else if (state_q == FO_IDLE) begin
            if (rsp_valid) begin
                state_q <= FO_SEND;
                cur_id  <= rsp_id;
                cur_idx <= '0;
            end
        end else if (out_ready) begin
            if (done) state_q <= FO_IDLE;
            else      cur_idx <= cur_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rsp_valid && rsp_ready) line_q <= rsp_data;
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(cur_id) && $stable(cur_idx)));
    // R8
    rsp_take_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> out_valid);
endmodule

// File: rtl/rcl_coalescer.sv
`timescale 1ns/1ps
module rcl_coalescer
    import rcl_pkg::*;
#(
    parameter int WADDR_W      = 13,
    parameter int TAG_W        = 6,
    parameter int ENTRIES      = 4,
    parameter int SLOTS        = 4,
    parameter int MAX_INFLIGHT = 2,
    parameter int HOLD         = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [WADDR_W-1:0]       in_waddr,
    input  logic [TAG_W-1:0]         in_tag,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [WADDR_W-4:0]       mem_req_line,
    output logic [$clog2(ENTRIES)-1:0] mem_req_id,
    input  logic                     mem_rsp_valid,
    output logic                     mem_rsp_ready,
    input  logic [$clog2(ENTRIES)-1:0] mem_rsp_id,
    input  logic [LINE_W-1:0]        mem_rsp_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [TAG_W-1:0]         out_tag,
    output logic [WORD_W-1:0]        out_data
);
    localparam int LADDR_W = WADDR_W - SEL_W;
    localparam int ID_W    = $clog2(ENTRIES);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int CNT_W   = $clog2(SLOTS + 1);
    localparam int FL_W    = $clog2(MAX_INFLIGHT + 1);
    localparam int AGE_W   = $clog2(HOLD + 1);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        wsel_t            sel;
    } slot_t;

    logic [ENTRIES-1:0] e_valid, e_issued;
    logic [LADDR_W-1:0] e_line [ENTRIES];
    logic [CNT_W-1:0]   e_cnt  [ENTRIES];
    logic [AGE_W-1:0]   e_age  [ENTRIES];
    slot_t              slots  [ENTRIES][SLOTS];
    logic [FL_W-1:0]    inflight_q;

    logic               hit;
    logic [ID_W-1:0]    hit_id, free_id, head_id, cur_id;
    logic               q_empty, head_ok, issue_fire, in_fire, rsp_fire, done;
    logic [SLOT_W-1:0]  cur_idx;
    logic [LADDR_W-1:0] req_line;
    slot_t              new_slot, cur_slot;

    assign req_line     = in_waddr[WADDR_W-1:SEL_W];
    assign new_slot.tag = in_tag;
    assign new_slot.sel = in_waddr[SEL_W-1:0];

    rcl_match #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .LADDR_W(LADDR_W),
                .CNT_W(CNT_W), .ID_W(ID_W)) match_i (
        .e_valid(e_valid), .e_issued(e_issued), .e_line(e_line), .e_cnt(e_cnt),
        .req_line(req_line), .hit(hit), .hit_id(hit_id), .free_id(free_id));

    assign in_ready = !(&e_valid);
    assign in_fire  = in_valid && in_ready;

    rcl_order_fifo #(.DEPTH(ENTRIES), .W(ID_W)) order_i (
        .clk(clk), .rst(rst), .push(in_fire && !hit), .din(free_id),
        .pop(issue_fire), .dout(head_id), .empty(q_empty));

    assign head_ok = !q_empty && (e_age[head_id] == AGE_W'(HOLD) || (&e_valid) ||
                                  e_cnt[head_id] == CNT_W'(SLOTS));
    assign mem_req_valid = head_ok && (inflight_q < FL_W'(MAX_INFLIGHT));
    assign mem_req_line  = e_line[head_id];
    assign mem_req_id    = head_id;
    assign issue_fire    = mem_req_valid && mem_req_ready;
    assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;

    assign cur_slot = slots[cur_id][cur_idx];
    assign out_tag  = cur_slot.tag;

    rcl_fanout #(.ID_W(ID_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) fanout_i (
        .clk(clk), .rst(rst), .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready),
        .rsp_id(mem_rsp_id), .rsp_data(mem_rsp_data), .cur_cnt(e_cnt[cur_id]),
        .cur_sel(cur_slot.sel), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .cur_id(cur_id), .cur_idx(cur_idx), .done(done));

    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid    <= '0;
            e_issued   <= '0;
            inflight_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_cnt[i] <= '0;
                e_age[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (e_valid[i] && !e_issued[i] && e_age[i] != AGE_W'(HOLD))
                    e_age[i] <= e_age[i] + 1'b1;
            end
            if (in_fire) begin
                if (hit) begin
                    e_cnt[hit_id] <= e_cnt[hit_id] + 1'b1;
                end else begin
                    e_valid[free_id]  <= 1'b1;
                    e_issued[free_id] <= 1'b0;
                    e_cnt[free_id]    <= CNT_W'(1);
                    e_age[free_id]    <= '0;
                end
            end
            if (issue_fire) e_issued[head_id] <= 1'b1;
            if (done)       e_valid[cur_id]   <= 1'b0;
            if (issue_fire && !rsp_fire)      inflight_q <= inflight_q + 1'b1;
            else if (rsp_fire && !issue_fire) inflight_q <= inflight_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (in_fire) begin
            if (hit) begin
                slots[hit_id][e_cnt[hit_id][SLOT_W-1:0]] <= new_slot;
            end else begin
                slots[free_id][0] <= new_slot;
                e_line[free_id]   <= req_line;
            end
        end
    end

    // R6
    inflight_cap_chk: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= FL_W'(MAX_INFLIGHT));
    // R8
    rsp_id_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fire |-> (e_valid[mem_rsp_id] && e_issued[mem_rsp_id]));
    // R5
    ready_free_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> in_ready);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent_chk
        // R3
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            e_cnt[gi] <= CNT_W'(SLOTS));
    end
endmodule

// File: tb/rcl_coalescer_tb.sv
`timescale 1ns/1ps
module rcl_coalescer_tb_top;
    localparam int WADDR_W = 13;
    localparam int TAG_W   = 6;
    localparam int ENTRIES = 4;
    localparam int SLOTS   = 4;
    localparam int MAXF    = 2;
    localparam int HOLD    = 4;
    localparam int ID_W    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [WADDR_W-1:0] in_waddr = '0;
    logic [TAG_W-1:0]   in_tag = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [WADDR_W-4:0] mem_req_line;
    logic [ID_W-1:0]    mem_req_id;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_ready;
    logic [ID_W-1:0]    mem_rsp_id = '0;
    logic [511:0]       mem_rsp_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [TAG_W-1:0]   out_tag;
    logic [63:0]        out_data;

    always #10 clk = ~clk;

    rcl_coalescer #(.WADDR_W(WADDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS),
                    .MAX_INFLIGHT(MAXF), .HOLD(HOLD)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_waddr(in_waddr), .in_tag(in_tag), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
        .mem_req_id(mem_req_id), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_id(mem_rsp_id),
        .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_data(out_data));

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [WADDR_W-1:0] t_addr [64];
    bit  t_open [64];
    int  t_seq [64];
    int  seq_ctr = 0;
    int  last_seq [1024];
    int  out_log [64];
    int  n_out = 0;
    int  req_log [64];
    int  n_req = 0;
    int  p_id [16];
    int  p_line [16];
    int  np = 0;
    bit  acc_en = 0, ret_en = 0, lifo = 0, ordy_mode = 0;
    bit  rsp_on = 0;
    int  rsp_slot = 0;
    bit  stall_prev = 0;
    logic [TAG_W-1:0] prev_tag;
    logic [63:0]      prev_data;

    function automatic logic [63:0] img(input int line, input int w);
        return {8'hD0, 8'(w), 16'(line), 32'(line * 7 + w * 13 + 1)};
    endfunction

    task automatic chk(input bit ok, input string r, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            finish_run();
        end
    end

    // memory model and output monitor
    always @(negedge clk) begin
        if (!rst) begin
            mem_req_ready = acc_en;
            out_ready = ordy_mode ? cyc[0] : 1'b1;
            if (!rsp_on) mem_rsp_valid = 1'b0;
            if (!rsp_on && ret_en && np > 0) begin
                rsp_slot = lifo ? np - 1 : 0;
                mem_rsp_valid = 1'b1;
                mem_rsp_id = ID_W'(p_id[rsp_slot]);
                for (int w = 0; w < 8; w++)
                    mem_rsp_data[w*64 +: 64] = img(p_line[rsp_slot], w);
                rsp_on = 1;
            end
            #2;
            if (mem_rsp_valid && mem_rsp_ready && rsp_on) begin
                for (int j = rsp_slot; j < np - 1; j++) begin
                    p_id[j] = p_id[j+1];
                    p_line[j] = p_line[j+1];
                end
                np--;
                rsp_on = 0;
            end
            if (mem_req_valid && mem_req_ready) begin
                p_id[np] = int'(mem_req_id);
                p_line[np] = int'(mem_req_line);
                np++;
                if (n_req < 64) req_log[n_req] = int'(mem_req_line);
                n_req++;
            end
            if (stall_prev) begin
                // R9 hold while stalled
                chk(out_valid && out_tag == prev_tag && out_data == prev_data,
                    "R9 hold", {58'd0, out_tag}, {58'd0, prev_tag});
            end
            stall_prev = out_valid && !out_ready;
            prev_tag = out_tag;
            prev_data = out_data;
            if (out_valid && out_ready) begin
                int tg, ln, wd;
                tg = int'(out_tag);
                ln = int'(t_addr[tg][WADDR_W-1:3]);
                wd = int'(t_addr[tg][2:0]);
                chk(t_open[tg], "R8 tag outstanding", 64'(tg), 64'(tg));
                chk(out_data == img(ln, wd), "R7 word data", out_data, img(ln, wd));
                chk(t_seq[tg] > last_seq[ln], "R9 line order",
                    64'(t_seq[tg]), 64'(last_seq[ln]));
                last_seq[ln] = t_seq[tg];
                t_open[tg] = 0;
                if (n_out < 64) out_log[n_out] = tg;
                n_out++;
            end
        end
    end

    task automatic send(input int line, input int w, input int tag);
        t_addr[tag] = WADDR_W'(line * 8 + w);
        t_open[tag] = 1;
        t_seq[tag] = ++seq_ctr;
        @(negedge clk);
        in_valid = 1'b1;
        in_waddr = t_addr[tag];
        in_tag = TAG_W'(tag);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string r);
        int w = 0;
        bit busy = 1;
        while (busy && w < 3000) begin
            @(negedge clk);
            #3;
            w++;
            busy = np > 0 || rsp_on || out_valid;
            for (int t = 0; t < 64; t++) if (t_open[t]) busy = 1;
        end
        chk(!busy, r, 64'(w), 64'(3000));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) last_seq[i] = 0;
        for (int i = 0; i < 64; i++) t_open[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #3;
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R2 merge of four words of one line into one read
        acc_en = 1; ret_en = 1; lifo = 0;
        n_req = 0; n_out = 0;
        send(5, 7, 0); send(5, 2, 1); send(5, 5, 2); send(5, 0, 3);
        drain("R2 drain");
        chk(n_req == 1, "R2 single line read", 64'(n_req), 64'd1);
        chk(req_log[0] == 5, "R2 line address", 64'(req_log[0]), 64'd5);
        for (int k = 0; k < 4; k++)
            chk(out_log[k] == k, "R9 request order", 64'(out_log[k]), 64'(k));

        // R3 slot overflow opens a second entry
        n_req = 0; n_out = 0;
        for (int k = 0; k < 5; k++) send(9, k, 10 + k);
        drain("R3 drain");
        chk(n_req == 2, "R3 two line reads", 64'(n_req), 64'd2);
        chk(req_log[1] == 9, "R3 second read line", 64'(req_log[1]), 64'd9);
        chk(n_out == 5, "R8 one output each", 64'(n_out), 64'd5);

        // R5 full window, R6 cap, R4 order, R8 out-of-order returns
        n_req = 0; n_out = 0;
        acc_en = 0;
        for (int k = 0; k < 4; k++) send(20 + k, k, 20 + k);
        @(negedge clk);
        #3;
        chk(in_ready == 1'b0, "R5 ready low when full", 64'(in_ready), 64'd0);
        chk(mem_req_valid == 1'b1, "R4 offer when full", 64'(mem_req_valid), 64'd1);
        ret_en = 0; acc_en = 1;
        repeat (15) @(negedge clk);
        #3;
        chk(n_req == MAXF, "R6 inflight cap", 64'(n_req), 64'(MAXF));
        chk(req_log[0] == 20, "R4 first issued", 64'(req_log[0]), 64'd20);
        chk(req_log[1] == 21, "R4 second issued", 64'(req_log[1]), 64'd21);
        lifo = 1; ret_en = 1;
        drain("R8 drain");
        chk(n_req == 4, "R6 all issued", 64'(n_req), 64'd4);
        chk(req_log[2] == 22 && req_log[3] == 23, "R4 later order",
            64'(req_log[3]), 64'd23);
        chk(n_out == 4, "R8 reverse returns", 64'(n_out), 64'd4);
        chk(in_ready == 1'b1, "R5 ready back", 64'(in_ready), 64'd1);

        // R4 hold time for a lone entry
        n_req = 0; lifo = 0;
        send(40, 3, 30);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            #1;
            chk(mem_req_valid == (k == 5), "R4 hold age",
                64'(mem_req_valid), 64'(k == 5));
        end
        drain("R4 drain");
        chk(n_req == 1, "R4 lone read", 64'(n_req), 64'd1);

        // sweep: all words of four lines, word-major, stalled consumer
        n_req = 0; n_out = 0; ordy_mode = 1; lifo = 1;
        for (int w = 0; w < 8; w++)
            for (int l = 0; l < 4; l++) send(50 + l, (w + 3 * l) % 8, w * 4 + l);
        drain("R7 sweep drain");
        chk(n_out == 32, "R8 sweep outputs", 64'(n_out), 64'd32);
        chk(n_req >= 8, "R3 sweep reads", 64'(n_req), 64'd8);

        finish_run();
    end
endmodule